// File: doc/BRIEF.md
# Per-Channel Automatic Offset Servo

This block holds the black level of a three-channel 8-bit video digitizer at a programmed code. In each back-porch reference interval, marked by a clamp window input, it averages the first few raw converter samples of each channel. It compares that mean with the channel's target code and moves the channel's offset control word one step toward the target. The control word drives an analog offset stage outside this block, so the loop closes through the converter and settles over a number of lines.

The same per-channel offset registers have two uses. With automatic mode off, they pass straight through as manual offset control words, and samples leave the block unchanged. With automatic mode on, the servo owns the control words, and each register is read as a signed two's complement brightness value. That value is added to every sample, and the sum saturates to the code range. Programming zero leaves samples unaltered.

Top module: `auto_offset_loop`

## Requirements
- R1: While reset is held high, every servo word is set to midscale (64 for a 7-bit word) and every sample output is set to 0.
- R2: With auto_en low, ofs_ctrl of each channel equals that channel's ofs_reg in the same cycle, and pix_out is the adc_code of the previous cycle, unchanged.
- R3: With auto_en high, pix_out is the previous cycle's adc_code plus ofs_reg read as 7-bit two's complement (-64..63), with the sum limited to 0..255.
- R4: The servo compares floor(sum/4) of the first four raw adc_code samples in a clamp window. It does not use the brightness-adjusted samples, and it ignores samples after the fourth.
- R5: In the cycle after clamp_win falls, each servo word moves up by one if mean + 1 < target, moves down by one if mean > target + 1, and holds otherwise. It changes at no other time.
- R6: A servo word saturates at 0 and 127 and never wraps.
- R7: A clamp window with fewer than four samples causes no step.
- R8: A target code of 0 acts as 1, and 255 acts as 254.
- R9: With auto_en low, servo words do not move and keep their value, and ofs_ctrl shows the servo word again once auto_en returns high.
- R10: The three channels step independently, each from its own samples and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Automatic offset mode enable |
| clamp_win | input | 1 | Back-porch reference window, active high |
| adc_code | input | NCH*DW | Raw converter sample per channel |
| target_code | input | NCH*DW | Desired back-porch code per channel |
| ofs_reg | input | NCH*OW | Manual offset, or signed brightness in automatic mode |
| ofs_ctrl | output | NCH*OW | Offset control word per channel |
| pix_out | output | NCH*DW | Adjusted sample per channel, one cycle after input |

## Verification
The bench uses the default build: three channels, 8-bit samples, 7-bit offset words and a four-sample averaging window. With these values the brightness adder can be swept over all 128 offset values against all 256 input codes, so every saturation corner of R3 is reached. A 7-bit servo word also makes it cheap to drive the servo all the way to both rails, one line per step. The four-sample mean allows the deadband edges of R5, the early window closes of R7 and the target remapping of R8 to be reached by chosen ramps.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic sample;   // accumulate this cycle's sample
        logic close;    // window just ended with a full sample set
        logic idle;     // no window open
    } win_ctl_t;

    function automatic int sat_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int target_limit(input int t, input int code_max);
        return sat_int(t, 1, code_max - 1);
    endfunction

    function automatic step_e step_decide(input int mean, input int tgt);
        if (mean + 1 < tgt) return STEP_UP;
        if (mean > tgt + 1) return STEP_DOWN;
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/oc_window.sv
module oc_window
    import oc_pkg::*;
#(
    parameter int AVG_LOG2 = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clamp_win,
    output win_ctl_t ctl
);
    localparam int NSAMP = 1 << AVG_LOG2;
    localparam int CW    = AVG_LOG2 + 1;
    localparam logic [CW-1:0] NS_C = CW'(NSAMP);

    logic [CW-1:0] cnt;
    logic          clamp_q;

    always_comb begin
        ctl.sample = clamp_win && (cnt < NS_C);
        ctl.close  = clamp_q && !clamp_win && (cnt == NS_C);
        ctl.idle   = !clamp_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            clamp_q <= 1'b0;
        end else begin
            clamp_q <= clamp_win;
            if (!clamp_win)
                cnt <= '0;
            else if (ctl.sample)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/oc_servo.sv
module oc_servo
    import oc_pkg::*;
#(
    parameter int DW       = 8,
    parameter int OW       = 7,
    parameter int AVG_LOG2 = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_en,
    input  win_ctl_t      ctl,
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] target,
    output logic [OW-1:0] word
);
    localparam int SW       = DW + AVG_LOG2;
    localparam int CODE_MAX = (1 << DW) - 1;
    localparam logic [OW-1:0] W_MAX = '1;
    localparam logic [OW-1:0] W_MIN = '0;
    localparam logic [OW-1:0] W_MID = {1'b1, {(OW-1){1'b0}}};

    logic [SW-1:0] sum;
    logic [DW-1:0] mean;
    step_e         step;
    logic [OW-1:0] word_nx;

    always_comb begin
        mean = sum[SW-1:AVG_LOG2];
        step = step_decide(int'(mean), target_limit(int'(target), CODE_MAX));
        unique case (step)
            STEP_UP:   word_nx = (word == W_MAX) ? word : word + 1'b1;
            STEP_DOWN: word_nx = (word == W_MIN) ? word : word - 1'b1;
            default:   word_nx = word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum  <= '0;
            word <= W_MID;
        end else begin
            if (ctl.idle)
                sum <= '0;
            else if (ctl.sample)
                sum <= sum + SW'(sample);
            if (auto_en && ctl.close)
                word <= word_nx;
        end
    end
endmodule

// File: rtl/oc_bright.sv
module oc_bright
    import oc_pkg::*;
#(
    parameter int DW = 8,
    parameter int OW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_en,
    input  logic [DW-1:0] sample,
    input  logic [OW-1:0] ofs,
    output logic [DW-1:0] pix
);
    localparam int CODE_MAX = (1 << DW) - 1;

    int            total;
    logic [DW-1:0] pix_nx;

    always_comb begin
        total  = sat_int(int'(sample) + int'($signed(ofs)), 0, CODE_MAX);
        pix_nx = auto_en ? DW'(total) : sample;
    end

    always_ff @(posedge clk) begin
        if (rst) pix <= '0;
        else     pix <= pix_nx;
    end
endmodule

// File: rtl/auto_offset_loop.sv
module auto_offset_loop
    import oc_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int DW       = 8,
    parameter int OW       = 7,
    parameter int AVG_LOG2 = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    auto_en,
    input  logic                    clamp_win,
    input  logic [NCH-1:0][DW-1:0]  adc_code,
    input  logic [NCH-1:0][DW-1:0]  target_code,
    input  logic [NCH-1:0][OW-1:0]  ofs_reg,
    output logic [NCH-1:0][OW-1:0]  ofs_ctrl,
    output logic [NCH-1:0][DW-1:0]  pix_out
);
    win_ctl_t              ctl;
    logic [NCH-1:0][OW-1:0] srv_word;

    oc_window #(.AVG_LOG2(AVG_LOG2)) u_win (
        .clk       (clk),
        .rst       (rst),
        .clamp_win (clamp_win),
        .ctl       (ctl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        oc_servo #(.DW(DW), .OW(OW), .AVG_LOG2(AVG_LOG2)) u_srv (
            .clk     (clk),
            .rst     (rst),
            .auto_en (auto_en),
            .ctl     (ctl),
            .sample  (adc_code[c]),
            .target  (target_code[c]),
            .word    (srv_word[c])
        );

        oc_bright #(.DW(DW), .OW(OW)) u_brt (
            .clk     (clk),
            .rst     (rst),
            .auto_en (auto_en),
            .sample  (adc_code[c]),
            .ofs     (ofs_reg[c]),
            .pix     (pix_out[c])
        );

        assign ofs_ctrl[c] = auto_en ? srv_word[c] : ofs_reg[c];
    end
endmodule

// File: rtl/auto_offset_loop_chk.sv
module auto_offset_loop_chk #(
    parameter int NCH = 3,
    parameter int DW  = 8,
    parameter int OW  = 7
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    auto_en,
    input logic                    clamp_win,
    input logic [NCH-1:0][DW-1:0]  adc_code,
    input logic [NCH-1:0][OW-1:0]  ofs_reg,
    input logic [NCH-1:0][OW-1:0]  ofs_ctrl,
    input logic [NCH-1:0][DW-1:0]  pix_out
);
    for (genvar c = 0; c < NCH; c++) begin : g_a
        p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
            (auto_en && $past(auto_en) && !$past(rst)) |->
            ((ofs_ctrl[c] == $past(ofs_ctrl[c])) ||
             (ofs_ctrl[c] == $past(ofs_ctrl[c]) + 1'b1) ||
             (ofs_ctrl[c] + 1'b1 == $past(ofs_ctrl[c]))));

        p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            (auto_en && $past(auto_en) && !$past(rst) && !$past(rst, 2) &&
             !($past(clamp_win, 2) && !$past(clamp_win))) |->
            (ofs_ctrl[c] == $past(ofs_ctrl[c])));

        p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
            (auto_en && $past(auto_en) && !$past(rst) && ($past(ofs_ctrl[c]) == '1)) |->
            (ofs_ctrl[c] != '0));

        p_no_wrap_low_r6: assert property (@(posedge clk) disable iff (rst)
            (auto_en && $past(auto_en) && !$past(rst) && ($past(ofs_ctrl[c]) == '0)) |->
            (ofs_ctrl[c] != '1));

        p_manual_pix_r2: assert property (@(posedge clk) disable iff (rst)
            (!$past(auto_en) && !$past(rst)) |-> (pix_out[c] == $past(adc_code[c])));

        p_zero_ofs_r3: assert property (@(posedge clk) disable iff (rst)
            ($past(auto_en) && !$past(rst) && ($past(ofs_reg[c]) == '0)) |->
            (pix_out[c] == $past(adc_code[c])));
    end
endmodule

bind auto_offset_loop auto_offset_loop_chk #(.NCH(NCH), .DW(DW), .OW(OW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .auto_en   (auto_en),
    .clamp_win (clamp_win),
    .adc_code  (adc_code),
    .ofs_reg   (ofs_reg),
    .ofs_ctrl  (ofs_ctrl),
    .pix_out   (pix_out)
);

// File: tb/auto_offset_loop_tb.sv
`timescale 1ns/1ps
module auto_offset_loop_tb;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             auto_en = 1'b0;
    logic             clamp_win = 1'b0;
    logic [2:0][7:0]  adc_code = '0;
    logic [2:0][7:0]  target_code = '0;
    logic [2:0][6:0]  ofs_reg = '0;
    logic [2:0][6:0]  ofs_ctrl;
    logic [2:0][7:0]  pix_out;

    int n_chk = 0;
    int n_bad = 0;
    int exp_srv [3];

    always #4 clk = ~clk;

    auto_offset_loop u_dut (
        .clk(clk), .rst(rst), .auto_en(auto_en), .clamp_win(clamp_win),
        .adc_code(adc_code), .target_code(target_code), .ofs_reg(ofs_reg),
        .ofs_ctrl(ofs_ctrl), .pix_out(pix_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int sx7(input int v);
        return (v >= 64) ? v - 128 : v;
    endfunction

    function automatic int lim(input int v, input int lo, input int hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    // one back-porch window: first four samples form a ramp, later ones are junk
    task automatic run_win(input string req, input int len,
                           input int base [3], input int dv [3]);
        int sum [3];
        for (int c = 0; c < 3; c++) sum[c] = 0;
        for (int i = 0; i < len; i++) begin
            clamp_win = 1'b1;
            for (int c = 0; c < 3; c++) begin
                int v;
                v = (i < 4) ? lim(base[c] + i * dv[c], 0, 255) : (255 - base[c]);
                adc_code[c] = 8'(v);
                if (i < 4) sum[c] += v;
            end
            @(negedge clk);
        end
        clamp_win = 1'b0;
        adc_code  = '0;
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            if (len >= 4 && auto_en) begin
                int m, t;
                m = sum[c] / 4;
                t = lim(int'(target_code[c]), 1, 254);
                if (m + 1 < t)      exp_srv[c] = lim(exp_srv[c] + 1, 0, 127);
                else if (m > t + 1) exp_srv[c] = lim(exp_srv[c] - 1, 0, 127);
            end
            chk(req, int'(ofs_ctrl[c]), auto_en ? exp_srv[c] : int'(ofs_reg[c]));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int b [3];
        int d [3];
        auto_en = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        for (int c = 0; c < 3; c++) begin
            exp_srv[c] = 64;
            chk("R1 srv", int'(ofs_ctrl[c]), 64);
            chk("R1 pix", int'(pix_out[c]), 0);
        end
        rst = 1'b0;
        auto_en = 1'b0;

        // R2: manual mode pass-through
        for (int a = 0; a < 256; a++) begin
            adc_code = {8'(a ^ 85), 8'(255 - a), 8'(a)};
            ofs_reg  = {7'(a + 5), 7'(a * 3), 7'(a)};
            #1;
            for (int c = 0; c < 3; c++) chk("R2 ctrl", int'(ofs_ctrl[c]), int'(ofs_reg[c]));
            @(negedge clk);
            chk("R2 pix0", int'(pix_out[0]), a);
            chk("R2 pix1", int'(pix_out[1]), 255 - a);
            chk("R2 pix2", int'(pix_out[2]), a ^ 85);
        end

        // R3: exhaustive brightness adder sweep
        auto_en = 1'b1;
        for (int o = 0; o < 128; o++) begin
            for (int a = 0; a < 256; a++) begin
                int ao [3];
                int oo [3];
                ao[0] = a; ao[1] = 255 - a; ao[2] = a ^ 85;
                oo[0] = o; oo[1] = o ^ 127; oo[2] = (o + 37) & 127;
                for (int c = 0; c < 3; c++) begin
                    adc_code[c] = 8'(ao[c]);
                    ofs_reg[c]  = 7'(oo[c]);
                end
                @(negedge clk);
                for (int c = 0; c < 3; c++)
                    chk("R3 adder", int'(pix_out[c]), lim(ao[c] + sx7(oo[c]), 0, 255));
            end
        end
        adc_code = '0;
        for (int c = 0; c < 3; c++) chk("R1 srv idle", int'(ofs_ctrl[c]), 64);

        // R5 R10: independent directions, brightness nonzero to show raw samples are used (R4)
        ofs_reg = {7'd20, 7'd20, 7'd20};
        target_code = {8'd200, 8'd128, 8'd10};
        b = '{5, 128, 210}; d = '{0, 0, 0};
        run_win("R10 dirs", 4, b, d);
        run_win("R10 dirs", 5, b, d);
        // R5 deadband edges on channel 0 (target 10)
        b = '{9, 11, 127}; run_win("R5 band", 4, b, d);
        b = '{11, 127, 129}; run_win("R5 band", 4, b, d);
        b = '{8, 130, 200}; run_win("R5 edge", 4, b, d);
        b = '{12, 126, 202}; run_win("R5 edge", 4, b, d);
        // R4: floor of ramp mean, samples past the fourth ignored
        b = '{6, 120, 190}; d = '{1, 3, 7};
        run_win("R4 ramp", 8, b, d);
        b = '{3, 140, 205}; d = '{3, -5, 1};
        run_win("R4 ramp", 12, b, d);
        // R7: short windows do nothing
        b = '{0, 0, 255}; d = '{0, 0, 0};
        run_win("R7 short", 3, b, d);
        run_win("R7 short", 1, b, d);
        // R8: target 255 acts as 254, 0 acts as 1
        target_code = {8'd0, 8'd255, 8'd0};
        b = '{0, 253, 2};
        run_win("R8 limit", 4, b, d);
        b = '{3, 251, 0};
        run_win("R8 limit", 4, b, d);
        // R6: drive to both rails
        target_code = {8'd254, 8'd254, 8'd254};
        b = '{0, 0, 0};
        for (int k = 0; k < 70; k++) run_win("R6 top", 4, b, d);
        for (int c = 0; c < 3; c++) chk("R6 top rail", int'(ofs_ctrl[c]), 127);
        target_code = {8'd1, 8'd1, 8'd1};
        b = '{255, 255, 255};
        for (int k = 0; k < 135; k++) run_win("R6 bottom", 4, b, d);
        for (int c = 0; c < 3; c++) chk("R6 bottom rail", int'(ofs_ctrl[c]), 0);

        // R9: frozen while auto mode is off, retained afterwards
        auto_en = 1'b0;
        ofs_reg = {7'd33, 7'd99, 7'd7};
        target_code = {8'd254, 8'd254, 8'd254};
        b = '{0, 0, 0};
        for (int k = 0; k < 3; k++) run_win("R9 frozen", 4, b, d);
        auto_en = 1'b1;
        #1;
        for (int c = 0; c < 3; c++) chk("R9 retained", int'(ofs_ctrl[c]), exp_srv[c]);
        run_win("R9 resume", 4, b, d);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule